// File: doc/BRIEF.md
# Nibble-Wide Ethernet Transmit Serializer

This block sits between a byte-stream MAC core and the four-bit transmit side of a media independent interface. It runs entirely on the transmit clock that the PHY supplies: 25 MHz at 100 Mbit/s, 2.5 MHz at 10 Mbit/s. Every output is registered on that clock. When a frame is offered, the block first sends the preamble and the start-of-frame delimiter. It then splits each accepted byte into two nibbles, low nibble first. The transmit enable stays high, with no gap, from the first preamble nibble to the last data nibble. Upstream flow control is a valid/ready/last handshake. The block takes at most one byte every two clocks.

The block does not compute CRC and does not add padding. If the source fails to supply a byte when one is requested in mid-frame, the frame is cut short. One nibble goes out with both enable and error high. The block then discards the rest of that upstream frame. Between frames it enforces a fixed minimum idle time on the line.

Top module: `mii_tx_serializer`

## Requirements
- R1: During and right after reset, `tx_en`, `tx_er`, `txd` and `in_ready` are all 0.
- R2: From idle, once the minimum gap has been met, `in_valid` high at a rising edge makes `tx_en` rise at that edge. In the same cycle `txd` shows the first preamble nibble, 4'h5.
- R3: The preamble is 15 nibbles of 4'h5 followed by one delimiter nibble of 4'hD (default PRE_NIBBLES = 16), all with `tx_en` high.
- R4: Each byte goes out as two consecutive nibbles: bits [3:0] first, then bits [7:4]. Byte bit 0 (and bit 4) appears on `txd[0]`.
- R5: `tx_en` stays high without a break from the first preamble nibble through the high nibble of the byte marked `in_last`. It falls in the next cycle.
- R6: `txd` is 4'h0 whenever `tx_en` is low.
- R7: During a frame, `in_ready` is high only in the cycle showing the delimiter nibble and in the cycle showing the high nibble of a byte that was not marked last. It is never high in two consecutive frame cycles.
- R8: If `in_ready` is high in a frame cycle while `in_valid` is low, the next cycle shows `tx_en`=1, `tx_er`=1 and `txd`=0. In the cycle after that, `tx_en` and `tx_er` are 0.
- R9: After an abort, `in_ready` stays high with `tx_en` low. Every upstream beat is discarded, up to and including the first beat with `in_last`.
- R10: After `tx_en` falls, it stays low for at least GAP_NIBBLES (default 24) cycles. If data is waiting, it rises again after exactly 24 cycles.
- R11: `tx_er` is never high while `tx_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock from the PHY |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Upstream frame byte |
| in_valid | input | 1 | Upstream byte present |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Block accepts the byte at this edge |
| txd | output | 4 | Transmit nibble, bit 0 least significant |
| tx_en | output | 1 | Transmit enable |
| tx_er | output | 1 | Transmit error (frame aborted) |

## Verification
A wrong preamble counter shows at the ports in the first frame. Either the delimiter appears in the wrong cycle, or `in_ready` rises too early or too late. Both are visible within 16 cycles of `tx_en` rising. A wrong nibble-phase flag swaps or repeats nibbles, or changes the cadence of `in_ready`, in the very next byte. A wrong gap counter moves the next rise of `tx_en` away from exactly 24 idle cycles, and back-to-back frames expose this at once. A stuck abort path either keeps `in_ready` high with the line idle, or sends data after a missed byte. The bench compares every cycle, so each fault is caught in the first cycle where it diverges.

// File: rtl/mii_tx_serializer.sv
module mii_tx_serializer #(
  parameter int PRE_NIBBLES = 16,
  parameter int GAP_NIBBLES = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic [3:0] txd,
  output logic       tx_en,
  output logic       tx_er
);
  localparam int MAXC = (PRE_NIBBLES > GAP_NIBBLES) ? PRE_NIBBLES : GAP_NIBBLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PRE_LAST = CW'(PRE_NIBBLES - 1);
  localparam logic [CW-1:0] PRE_SFD  = CW'(PRE_NIBBLES - 2);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_NIBBLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_DATA, S_ERR, S_DRAIN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [3:0]    hi_nib;
  logic          hi_pend, last_q;

  wire want = (st == S_PRE && cnt == PRE_LAST) ||
              (st == S_DATA && !hi_pend && !last_q);
  assign in_ready = want || st == S_DRAIN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= GAP_LAST;
      txd <= 4'h0;
      tx_en <= 1'b0;
      tx_er <= 1'b0;
      hi_nib <= 4'h0;
      hi_pend <= 1'b0;
      last_q <= 1'b0;
    end else if (want) begin
      if (in_valid) begin
        st <= S_DATA;
        txd <= in_data[3:0];
        hi_nib <= in_data[7:4];
        hi_pend <= 1'b1;
        last_q <= in_last;
      end else begin
        st <= S_ERR;
        txd <= 4'h0;
        tx_er <= 1'b1;
      end
    end else begin
      case (st)
        S_IDLE: begin
          if (cnt == GAP_LAST && in_valid) begin
            st <= S_PRE;
            cnt <= '0;
            tx_en <= 1'b1;
            txd <= 4'h5;
          end else if (cnt != GAP_LAST) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PRE: begin
          cnt <= cnt + 1'b1;
          txd <= (cnt == PRE_SFD) ? 4'hD : 4'h5;
        end
        S_DATA: begin
          if (hi_pend) begin
            txd <= hi_nib;
            hi_pend <= 1'b0;
          end else begin
            st <= S_IDLE;
            cnt <= '0;
            tx_en <= 1'b0;
            txd <= 4'h0;
          end
        end
        S_ERR: begin
          st <= S_DRAIN;
          tx_en <= 1'b0;
          tx_er <= 1'b0;
        end
        default: begin
          if (in_valid && in_last) begin
            st <= S_IDLE;
            cnt <= '0;
          end
        end
      endcase
    end
  end

  logic [CW-1:0] low_run;
  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= CW'(GAP_NIBBLES);
    else if (tx_en) low_run <= '0;
    else if (low_run != CW'(GAP_NIBBLES)) low_run <= low_run + 1'b1;
  end

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> txd == 4'h0);
  // R11
  err_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_er |-> tx_en);
  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_er |=> !tx_en && !tx_er);
  // R2
  first_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> txd == 4'h5);
  // R10
  gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> low_run == CW'(GAP_NIBBLES));
  // R7
  ready_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && st != S_DRAIN) |=> !in_ready);
endmodule

// File: tb/sim_mii_tx_serializer.sv
module sim_mii_tx_serializer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic in_ready, tx_en, tx_er;
  logic [3:0] txd;

  mii_tx_serializer u0 (.clk(clk), .rst_n(rst_n), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .txd(txd), .tx_en(tx_en), .tx_er(tx_er));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  typedef struct { logic [7:0] d; bit last; int gap; } beat_t;
  beat_t src[$];
  bit hs = 0;

  task automatic add_frame(input int n, input int seed, input int stall_idx, input int stall_len);
    for (int i = 0; i < n; i++) begin
      beat_t b;
      b.d = 8'((seed * 37 + i * 73 + 5) & 255);
      b.last = (i == n - 1);
      b.gap = (i == stall_idx) ? stall_len : 0;
      src.push_back(b);
    end
  endtask

  always @(posedge clk) hs = in_valid && in_ready;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hs) void'(src.pop_front());
      hs = 0;
      if (src.size() > 0) begin
        if (src[0].gap > 0) begin
          in_valid = 0;
          src[0].gap--;
        end else begin
          in_valid = 1;
          in_data = src[0].d;
          in_last = src[0].last;
        end
      end else begin
        in_valid = 0;
      end
    end
  end

  // reference model: 0 idle, 1 frame, 2 error nibble, 3 drain
  int mode = 0, gap = 24;
  bit last_got = 0;
  logic [3:0] nq[$];
  string tq[$];
  logic exp_en = 0, exp_er = 0;
  logic [3:0] exp_d = 0;
  string tag = "R1";

  task automatic show_next();
    exp_en = 1; exp_er = 0;
    exp_d = nq.pop_front();
    tag = tq.pop_front();
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; gap = 24; last_got = 0; nq.delete(); tq.delete();
      exp_en = 0; exp_er = 0; exp_d = 0; tag = "R1";
    end else begin
      case (mode)
        0: begin
          if (gap >= 24 && in_valid) begin
            for (int i = 0; i < 15; i++) begin nq.push_back(4'h5); tq.push_back("R3"); end
            nq.push_back(4'hD); tq.push_back("R3");
            show_next();
            tag = "R2";
            last_got = 0;
            mode = 1;
          end else begin
            if (gap < 24) gap++;
            exp_en = 0; exp_er = 0; exp_d = 0; tag = "R10";
          end
        end
        1: begin
          if (nq.size() > 0) show_next();
          else if (last_got) begin
            exp_en = 0; exp_er = 0; exp_d = 0; tag = "R5";
            mode = 0; gap = 1;
          end else if (in_valid) begin
            nq.push_back(in_data[7:4]); tq.push_back("R4");
            exp_en = 1; exp_er = 0; exp_d = in_data[3:0]; tag = "R4";
            last_got = in_last;
          end else begin
            exp_en = 1; exp_er = 1; exp_d = 0; tag = "R8";
            mode = 2;
          end
        end
        2: begin
          exp_en = 0; exp_er = 0; exp_d = 0; tag = "R8";
          mode = 3;
        end
        default: begin
          exp_en = 0; exp_er = 0; exp_d = 0; tag = "R9";
          if (in_valid && in_last) begin mode = 0; gap = 1; end
        end
      endcase
    end
  end

  int low_run = 1000;
  bit prev_en = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_rdy;
      exp_rdy = (mode == 1 && nq.size() == 0 && !last_got) || mode == 3;
      chk(tx_en === exp_en, tag, tx_en, exp_en);
      chk(tx_er === exp_er, (exp_er ? "R8" : "R11"), tx_er, exp_er);
      chk(txd === exp_d, (exp_en ? tag : "R6"), txd, exp_d);
      chk(in_ready === exp_rdy, (mode == 3 ? "R9" : "R7"), in_ready, exp_rdy);
      if (tx_en && !prev_en) chk(low_run >= 24, "R10", low_run, 24);
      low_run = tx_en ? 0 : low_run + 1;
      prev_en = tx_en;
    end
  end

  initial begin
    bit timed_out = 0;
    repeat (3) @(posedge clk);
    #5;
    // R1: reset values
    chk(tx_en === 0 && tx_er === 0 && txd === 0 && in_ready === 0, "R1",
        {tx_en, tx_er, txd, in_ready}, 0);
    add_frame(1, 1, -1, 0);
    add_frame(4, 2, -1, 0);
    add_frame(6, 3, 2, 1);
    add_frame(3, 4, 1, 5);
    add_frame(2, 5, -1, 0);
    add_frame(5, 6, 0, 30);
    add_frame(4, 7, 3, 2);
    add_frame(3, 8, -1, 0);
    @(negedge clk);
    rst_n = 1;
    begin
      int cyc = 0;
      while ((src.size() > 0 || mode != 0) && !timed_out) begin
        @(negedge clk);
        cyc++;
        if (cyc > 100000) timed_out = 1;
      end
    end
    repeat (30) @(negedge clk);
    if (timed_out) chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule